// File: doc/BRIEF.md
# Data-Flash Sector-Erase Command Front End

This block sits between the software-visible command registers of an embedded flash controller and the data-flash array. It handles one command, the sector erase. When software pulses `launch`, the block checks the loaded command parameters in that same cycle: the parameter index, whether the operating mode allows the command, the 23-bit global address and whether the addressed sector is protected. A failed check sets a sticky error flag. The command then does not run, and the command-complete flag never drops.

A command that passes every check starts a fixed-length erase/verify sequence. The sequence is a stand-in for the real array timing. During that sequence, verify-fault strobes from a stubbed array are gathered into a two-bit severity status, which is published when the sequence ends. A second pair of sticky flags records single-bit and double-bit ECC faults reported by a stubbed read decoder. All four sticky flags are cleared by write-one-to-clear strobes.

Two interrupt requests are built from the flags. The command request comes from the complete flag and its enable. The error request comes from the two ECC fault flags, each with its own enable. One global mask gates both requests.

Top module: `fcmd_erase_front`

## Requirements
- R1: A launch accepted while `param_idx` is not 3'b001 sets `acc_err` on the next cycle, and the command does not run: `cmd_done` stays 1 and `array_busy` stays 0.
- R2: A launch accepted while `mode_ok` is 0 sets `acc_err`, and the command does not run.
- R3: A launch whose address is below DF_BASE (default 0x100000), or at or above DF_BASE+DF_SIZE (default 0x108000), sets `acc_err`, and the command does not run.
- R4: A launch with `gaddr[0]` = 1 sets `acc_err`, and the command does not run. A misaligned address raises no protection flag.
- R5: A launch with no access error whose address is at or above `prot_floor` sets `prot_viol`, and the command does not run.
- R6: An accepted launch clears `vstat` to 2'b00 on the next cycle, whether or not it runs. A launch that passes all checks drives `cmd_done` to 0 and `array_busy` to 1 for exactly ERASE_CYC cycles (default 4), after which `cmd_done` returns to 1.
- R7: At the end of a sequence, `vstat[1]` is 1 if `vfy_err` or `vfy_uncorr` was high on any cycle of the sequence, and `vstat[0]` is 1 only if `vfy_uncorr` was high.
- R8: A launch while `cmd_done` is 0 is ignored. It sets no flag and does not change when the running sequence completes.
- R9: `acc_err`, `prot_viol`, `sfd_flag` and `dfd_flag` are sticky. `ecc_sgl` and `ecc_dbl` set the two fault flags. Each flag clears on its `clr_*` strobe, and a set in the same cycle as a clear wins.
- R10: `irq_cmd` is 1 exactly when `cmd_done` and `cmd_ie` are 1 and `gmask` is 0.
- R11: `irq_err` is 1 exactly when `gmask` is 0 and either `dfd_flag` and `dfd_ie` are both 1 or `sfd_flag` and `sfd_ie` are both 1.
- R12: After reset, `cmd_done` is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | One-cycle command launch strobe |
| param_idx | input | 3 | Parameter index register value at launch |
| mode_ok | input | 1 | Command allowed in the current mode |
| gaddr | input | 23 | Global address of the sector |
| prot_floor | input | 23 | Addresses at or above this are protected |
| vfy_err | input | 1 | Stub array: verify fault this cycle |
| vfy_uncorr | input | 1 | Stub array: non-correctable verify fault this cycle |
| ecc_sgl | input | 1 | Stub decoder: single-bit read fault |
| ecc_dbl | input | 1 | Stub decoder: double-bit read fault |
| clr_acc | input | 1 | Clear strobe for `acc_err` |
| clr_pv | input | 1 | Clear strobe for `prot_viol` |
| clr_sfd | input | 1 | Clear strobe for `sfd_flag` |
| clr_dfd | input | 1 | Clear strobe for `dfd_flag` |
| cmd_ie | input | 1 | Command-complete interrupt enable |
| sfd_ie | input | 1 | Single-bit fault interrupt enable |
| dfd_ie | input | 1 | Double-bit fault interrupt enable |
| gmask | input | 1 | Global interrupt mask |
| cmd_done | output | 1 | Command-complete flag |
| array_busy | output | 1 | Sequence running, array in use |
| acc_err | output | 1 | Access-error flag |
| prot_viol | output | 1 | Protection-violation flag |
| vstat | output | 2 | Verify severity: [1] any fault, [0] non-correctable |
| sfd_flag | output | 1 | Single-bit ECC fault flag |
| dfd_flag | output | 1 | Double-bit ECC fault flag |
| irq_cmd | output | 1 | Command interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The properties assume that `launch` and each `clr_*` strobe are synchronous single-cycle pulses. They also assume that an error flag is never cleared in the same cycle as a launch that could set it, and that `prot_floor` stays fixed around a launch. The bench follows all of these. It pulses every strobe for one cycle between falling edges. It clears the error flags one cycle before each launch. It sets `prot_floor` once and never changes it. The verify and ECC strobes are driven only during, or well away from, a running sequence, so every status value the bench expects can be traced to one known cycle.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [2:0] LAST_PARAM_IDX = 3'b001;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  typedef struct packed {
    logic access;
    logic protect;
  } chk_res_t;

  localparam int FLAG_ACC = 0;
  localparam int FLAG_PV  = 1;
  localparam int FLAG_SFD = 2;
  localparam int FLAG_DFD = 3;
  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/fcmd_check.sv
module fcmd_check
  import fcmd_pkg::*;
#(
  parameter int          ADDR_W  = 23,
  parameter logic [22:0] DF_BASE = 23'h10_0000,
  parameter logic [22:0] DF_SIZE = 23'h00_8000
) (
  input  logic [2:0]        param_idx,
  input  logic              mode_ok,
  input  logic [ADDR_W-1:0] gaddr,
  input  logic [ADDR_W-1:0] prot_floor,
  output chk_res_t          res
);
  localparam int          EW     = ADDR_W + 1;
  localparam logic [EW-1:0] BASE_X = EW'(DF_BASE);
  localparam logic [EW-1:0] END_X  = EW'(DF_BASE) + EW'(DF_SIZE);

  logic [EW-1:0] addr_x;
  logic idx_bad, range_bad, align_bad;

  always_comb begin
    addr_x    = {1'b0, gaddr};
    idx_bad   = (param_idx != LAST_PARAM_IDX);
    range_bad = (addr_x < BASE_X) || (addr_x >= END_X);
    align_bad = gaddr[0];
    res.access  = idx_bad || !mode_ok || range_bad || align_bad;
    res.protect = !res.access && (gaddr >= prot_floor);
  end
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int ERASE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       start,
  input  logic       vfy_err,
  input  logic       vfy_uncorr,
  output logic       busy,
  output logic [1:0] vstat
);
  localparam int CW = $clog2(ERASE_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ERASE_CYC - 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    acc_q, acc_d;
  logic [1:0]    vst_q, vst_d;
  logic [1:0]    cur;

  always_comb begin
    cur   = {vfy_err | vfy_uncorr, vfy_uncorr};
    st_d  = st_q;
    cnt_d = cnt_q;
    acc_d = acc_q;
    vst_d = vst_q;
    if (accept) vst_d = 2'b00;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d  = SEQ_RUN;
          cnt_d = CNT_LOAD;
          acc_d = 2'b00;
        end
      end
      SEQ_RUN: begin
        acc_d = acc_q | cur;
        if (cnt_q == '0) begin
          st_d  = SEQ_IDLE;
          vst_d = acc_q | cur;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      acc_q <= 2'b00;
      vst_q <= 2'b00;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      vst_q <= vst_d;
    end
  end

  assign busy  = (st_q == SEQ_RUN);
  assign vstat = vst_q;
endmodule

// File: rtl/fcmd_flag_bank.sv
module fcmd_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] flags
);
  logic [N-1:0] flg_q, flg_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flg_d[i] = flg_q[i];
      if (clr_v[i]) flg_d[i] = 1'b0;
      if (set_v[i]) flg_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q[i] <= 1'b0;
      else        flg_q[i] <= flg_d[i];
    end
  end

  assign flags = flg_q;
endmodule

// File: rtl/fcmd_erase_front.sv
module fcmd_erase_front
  import fcmd_pkg::*;
#(
  parameter int          ADDR_W    = 23,
  parameter logic [22:0] DF_BASE   = 23'h10_0000,
  parameter logic [22:0] DF_SIZE   = 23'h00_8000,
  parameter int          ERASE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [2:0]        param_idx,
  input  logic              mode_ok,
  input  logic [ADDR_W-1:0] gaddr,
  input  logic [ADDR_W-1:0] prot_floor,
  input  logic              vfy_err,
  input  logic              vfy_uncorr,
  input  logic              ecc_sgl,
  input  logic              ecc_dbl,
  input  logic              clr_acc,
  input  logic              clr_pv,
  input  logic              clr_sfd,
  input  logic              clr_dfd,
  input  logic              cmd_ie,
  input  logic              sfd_ie,
  input  logic              dfd_ie,
  input  logic              gmask,
  output logic              cmd_done,
  output logic              array_busy,
  output logic              acc_err,
  output logic              prot_viol,
  output logic [1:0]        vstat,
  output logic              sfd_flag,
  output logic              dfd_flag,
  output logic              irq_cmd,
  output logic              irq_err
);
  chk_res_t             res;
  logic                 busy;
  logic                 accept, start;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flags;

  fcmd_check #(.ADDR_W(ADDR_W), .DF_BASE(DF_BASE), .DF_SIZE(DF_SIZE)) u_check (
    .param_idx (param_idx),
    .mode_ok   (mode_ok),
    .gaddr     (gaddr),
    .prot_floor(prot_floor),
    .res       (res)
  );

  assign accept = launch & ~busy;
  assign start  = accept & ~res.access & ~res.protect;

  fcmd_seq #(.ERASE_CYC(ERASE_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .start     (start),
    .vfy_err   (vfy_err),
    .vfy_uncorr(vfy_uncorr),
    .busy      (busy),
    .vstat     (vstat)
  );

  always_comb begin
    set_v           = '0;
    clr_v           = '0;
    set_v[FLAG_ACC] = accept & res.access;
    set_v[FLAG_PV]  = accept & res.protect;
    set_v[FLAG_SFD] = ecc_sgl;
    set_v[FLAG_DFD] = ecc_dbl;
    clr_v[FLAG_ACC] = clr_acc;
    clr_v[FLAG_PV]  = clr_pv;
    clr_v[FLAG_SFD] = clr_sfd;
    clr_v[FLAG_DFD] = clr_dfd;
  end

  fcmd_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set_v(set_v),
    .clr_v(clr_v),
    .flags(flags)
  );

  assign acc_err    = flags[FLAG_ACC];
  assign prot_viol  = flags[FLAG_PV];
  assign sfd_flag   = flags[FLAG_SFD];
  assign dfd_flag   = flags[FLAG_DFD];
  assign array_busy = busy;
  assign cmd_done   = ~busy;
  assign irq_cmd    = ~gmask & cmd_done & cmd_ie;
  assign irq_err    = ~gmask & ((dfd_flag & dfd_ie) | (sfd_flag & sfd_ie));
endmodule

// File: rtl/fcmd_erase_front_chk.sv
module fcmd_erase_front_chk #(
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              launch,
  input logic [2:0]        param_idx,
  input logic              mode_ok,
  input logic [ADDR_W-1:0] gaddr,
  input logic              vfy_uncorr,
  input logic              ecc_sgl,
  input logic              clr_acc,
  input logic              clr_sfd,
  input logic              cmd_ie,
  input logic              sfd_ie,
  input logic              dfd_ie,
  input logic              gmask,
  input logic              cmd_done,
  input logic              array_busy,
  input logic              acc_err,
  input logic [1:0]        vstat,
  input logic              sfd_flag,
  input logic              dfd_flag,
  input logic              irq_cmd,
  input logic              irq_err
);
  AST_IDX_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    launch && cmd_done && (param_idx != 3'b001) |=> acc_err && cmd_done && !array_busy); // R1
  AST_MODE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    launch && cmd_done && !mode_ok |=> acc_err && cmd_done); // R2
  AST_ODD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    launch && cmd_done && gaddr[0] |=> acc_err && cmd_done && !array_busy); // R4
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    array_busy |-> !cmd_done); // R6
  AST_LAUNCH_CLR_VSTAT: assert property (@(posedge clk) disable iff (!rst_n)
    launch && cmd_done |=> vstat == 2'b00); // R6
  AST_UNCORR_IMPLIES_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    vstat[0] |-> vstat[1]); // R7
  AST_VSTAT_UNCORR_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    array_busy && vfy_uncorr |=> array_busy || vstat[0]); // R7
  AST_BUSY_LAUNCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    array_busy && launch && !acc_err |=> !acc_err); // R8
  AST_SFD_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sfd && !ecc_sgl |=> !sfd_flag); // R9
  AST_SFD_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_sgl |=> sfd_flag); // R9
  AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err && !clr_acc |=> acc_err); // R9
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |-> !irq_cmd && !irq_err); // R10
  AST_CMD_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmd |-> cmd_done && cmd_ie); // R10
  AST_ERR_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (sfd_flag && sfd_ie) || (dfd_flag && dfd_ie)); // R11
endmodule

bind fcmd_erase_front fcmd_erase_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .launch    (launch),
  .param_idx (param_idx),
  .mode_ok   (mode_ok),
  .gaddr     (gaddr),
  .vfy_uncorr(vfy_uncorr),
  .ecc_sgl   (ecc_sgl),
  .clr_acc   (clr_acc),
  .clr_sfd   (clr_sfd),
  .cmd_ie    (cmd_ie),
  .sfd_ie    (sfd_ie),
  .dfd_ie    (dfd_ie),
  .gmask     (gmask),
  .cmd_done  (cmd_done),
  .array_busy(array_busy),
  .acc_err   (acc_err),
  .vstat     (vstat),
  .sfd_flag  (sfd_flag),
  .dfd_flag  (dfd_flag),
  .irq_cmd   (irq_cmd),
  .irq_err   (irq_err)
);

// File: tb/sim_fcmd_erase_front.sv
`timescale 1ns/100ps
module sim_fcmd_erase_front;
  localparam int ADDR_W    = 23;
  localparam int ERASE_CYC = 4;
  localparam int NV        = 11;
  localparam logic [22:0] FLOOR = 23'h10_7000;

  logic clk = 1'b0;
  logic rst_n;
  logic launch, mode_ok, vfy_err, vfy_uncorr, ecc_sgl, ecc_dbl;
  logic clr_acc, clr_pv, clr_sfd, clr_dfd, cmd_ie, sfd_ie, dfd_ie, gmask;
  logic [2:0] param_idx;
  logic [ADDR_W-1:0] gaddr, prot_floor;
  logic cmd_done, array_busy, acc_err, prot_viol, sfd_flag, dfd_flag, irq_cmd, irq_err;
  logic [1:0] vstat;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fcmd_erase_front #(.ERASE_CYC(ERASE_CYC)) u0 (.*);

  // entry: {idx[29:27], mode[26], addr[25:3], exp_acc[2], exp_pv[1], exp_run[0]}
  localparam logic [29:0] VEC [NV] = '{
    {3'd1, 1'b1, 23'h10_0000, 3'b001},  // R6 valid, first word
    {3'd2, 1'b1, 23'h10_0000, 3'b100},  // R1 index too high
    {3'd0, 1'b1, 23'h10_0000, 3'b100},  // R1 index zero
    {3'd1, 1'b0, 23'h10_0000, 3'b100},  // R2 mode forbids
    {3'd1, 1'b1, 23'h0F_FFFE, 3'b100},  // R3 below range
    {3'd1, 1'b1, 23'h10_8000, 3'b100},  // R3 at range end
    {3'd1, 1'b1, 23'h10_7FFE, 3'b010},  // R5 last word, protected
    {3'd1, 1'b1, 23'h10_0001, 3'b100},  // R4 odd address
    {3'd1, 1'b1, 23'h10_6FFE, 3'b001},  // R5 just below floor, runs
    {3'd1, 1'b1, 23'h10_7000, 3'b010},  // R5 at floor
    {3'd1, 1'b1, 23'h10_7001, 3'b100}   // R4 odd wins over protection
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_errs();
    @(negedge clk); clr_acc = 1'b1; clr_pv = 1'b1;
    @(negedge clk); clr_acc = 1'b0; clr_pv = 1'b0;
  endtask

  task automatic do_launch(input logic [2:0] idx, input logic md, input logic [22:0] ad);
    param_idx = idx; mode_ok = md; gaddr = ad; launch = 1'b1;
    @(negedge clk); launch = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    repeat (ERASE_CYC - 1) @(negedge clk);
    chk({tag, " still running"}, int'(cmd_done), 0);
    @(negedge clk);
    chk({tag, " complete"}, int'(cmd_done), 1);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!finished) $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; launch = 0; mode_ok = 1; vfy_err = 0; vfy_uncorr = 0;
    ecc_sgl = 0; ecc_dbl = 0; clr_acc = 0; clr_pv = 0; clr_sfd = 0; clr_dfd = 0;
    cmd_ie = 0; sfd_ie = 0; dfd_ie = 0; gmask = 0; param_idx = 3'd1;
    gaddr = 23'h10_0000; prot_floor = FLOOR;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cmd_done", int'(cmd_done), 1);
    chk("R12 flags", int'({array_busy, acc_err, prot_viol, sfd_flag, dfd_flag}), 0);
    chk("R12 vstat", int'(vstat), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      clear_errs();
      do_launch(VEC[i][29:27], VEC[i][26], VEC[i][25:3]);
      chk($sformatf("R1-5 vec%0d acc_err", i), int'(acc_err), int'(VEC[i][2]));
      chk($sformatf("R5 vec%0d prot_viol", i), int'(prot_viol), int'(VEC[i][1]));
      chk($sformatf("R6 vec%0d busy", i), int'(array_busy), int'(VEC[i][0]));
      chk($sformatf("R6 vec%0d vstat", i), int'(vstat), 0);
      if (VEC[i][0]) wait_done($sformatf("R6 vec%0d", i));
    end
    param_idx = 3'd1; mode_ok = 1'b1; gaddr = 23'h10_0000;

    // R7 correctable verify fault
    clear_errs();
    do_launch(3'd1, 1'b1, 23'h10_0100);
    vfy_err = 1'b1; @(negedge clk); vfy_err = 1'b0;
    repeat (ERASE_CYC - 1) @(negedge clk);
    chk("R7 correctable vstat", int'(vstat), 2);
    // R7 non-correctable on the final cycle
    do_launch(3'd1, 1'b1, 23'h10_0200);
    chk("R6 launch clears vstat", int'(vstat), 0);
    repeat (ERASE_CYC - 1) @(negedge clk);
    vfy_uncorr = 1'b1; @(negedge clk); vfy_uncorr = 1'b0;
    chk("R7 uncorrectable vstat", int'(vstat), 3);
    // R6 rejected launch still clears vstat
    do_launch(3'd3, 1'b1, 23'h10_0000);
    chk("R6 error launch clears vstat", int'(vstat), 0);
    chk("R1 error launch keeps done", int'(cmd_done), 1);

    // R8 launch while busy
    clear_errs();
    do_launch(3'd1, 1'b1, 23'h10_0000);
    do_launch(3'd2, 1'b1, 23'h10_0001);
    chk("R8 busy launch no acc_err", int'(acc_err), 0);
    repeat (ERASE_CYC - 2) @(negedge clk);
    chk("R8 timing unchanged, running", int'(cmd_done), 0);
    @(negedge clk);
    chk("R8 timing unchanged, done", int'(cmd_done), 1);
    param_idx = 3'd1; gaddr = 23'h10_0000;

    // R10 command interrupt
    cmd_ie = 1'b1; #1;
    chk("R10 irq_cmd enabled", int'(irq_cmd), 1);
    gmask = 1'b1; #1;
    chk("R10 irq_cmd masked", int'(irq_cmd), 0);
    gmask = 1'b0;
    @(negedge clk);
    do_launch(3'd1, 1'b1, 23'h10_0000);
    chk("R10 irq_cmd while busy", int'(irq_cmd), 0);
    wait_done("R10 seq");
    chk("R10 irq_cmd after done", int'(irq_cmd), 1);
    cmd_ie = 1'b0; #1;
    chk("R10 irq_cmd disabled", int'(irq_cmd), 0);

    // R9 / R11 ECC fault flags
    @(negedge clk); ecc_sgl = 1'b1; @(negedge clk); ecc_sgl = 1'b0;
    chk("R9 sfd set", int'(sfd_flag), 1);
    chk("R11 sfd not enabled", int'(irq_err), 0);
    sfd_ie = 1'b1; #1;
    chk("R11 sfd irq", int'(irq_err), 1);
    gmask = 1'b1; #1;
    chk("R11 masked", int'(irq_err), 0);
    gmask = 1'b0;
    @(negedge clk); clr_sfd = 1'b1; @(negedge clk); clr_sfd = 1'b0;
    chk("R9 sfd cleared", int'(sfd_flag), 0);
    chk("R11 no source", int'(irq_err), 0);
    ecc_dbl = 1'b1; clr_dfd = 1'b1; @(negedge clk); ecc_dbl = 1'b0; clr_dfd = 1'b0;
    chk("R9 set wins over clear", int'(dfd_flag), 1);
    chk("R11 dfd not enabled", int'(irq_err), 0);
    dfd_ie = 1'b1; #1;
    chk("R11 dfd irq", int'(irq_err), 1);
    @(negedge clk); clr_dfd = 1'b1; @(negedge clk); clr_dfd = 1'b0;
    chk("R9 dfd cleared", int'(dfd_flag), 0);

    // R9 sticky access error until cleared
    clear_errs();
    do_launch(3'd1, 1'b0, 23'h10_0000);
    repeat (3) @(negedge clk);
    chk("R9 acc_err sticky", int'(acc_err), 1);
    @(negedge clk); clr_acc = 1'b1; @(negedge clk); clr_acc = 1'b0;
    chk("R9 acc_err cleared", int'(acc_err), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule